// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block decides which of six interrupt sources a processor core is sent to next. Each source raises a request flag. The request passes to arbitration only when its own enable bit and the global enable bit are both set. A second register places every source in either the low or the high priority level. The block then issues one vector address along with a valid strobe. The core confirms that it has taken the vector through an acknowledge input, and it reports the end of a service routine through a return input.

The controller records nesting with one in-service bit per level. A low-level routine may be interrupted by a high-level request, but not by another low-level request. A high-level routine is never interrupted. Between the two levels, the high level wins. Inside a level, a fixed order picks the winner: external 0 first, then timer 0, external 1, timer 1, serial, and timer 2 last. Arbitration runs every clock, and each clock stands for one machine cycle.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the enable readback, the priority readback, the in-service bits and the vector valid strobe are all zero.
- R2: Enable register layout: bit 7 is the global enable, bit 6 always reads 0, and bits 5..0 enable sources 0..5. Source 0 is external 0, 1 is timer 0, 2 is external 1, 3 is timer 1, 4 is serial and 5 is timer 2. Priority register layout: bits 5..0 set a source to high level when 1, and bits 7..6 always read 0. A write is visible on the readback one cycle later.
- R3: The vector address for source i is 8*i + 3, which gives 0x0003, 0x000B, 0x0013, 0x001B, 0x0023 and 0x002B.
- R4: A request produces no vector unless both the global enable and that source's enable are 1.
- R5: When requests are eligible at both levels, the vector goes to a high-level source and vec_level reads 1.
- R6: Within one level, the eligible source with the lowest index is chosen.
- R7: An acknowledge while vec_valid is 1 sets the in-service bit of the level given by vec_level. Because that level is now blocked, vec_valid falls on the same edge.
- R8: While only the low in-service bit is set, low-level requests produce no vector and high-level requests still do.
- R9: While the high in-service bit is set, no vector is issued.
- R10: A return clears the high in-service bit if it is set, and clears the low bit otherwise.
- R11: vec_valid, vec_addr and vec_level are registered. They reflect the requests, registers and in-service state sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per period |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 6 | Request flags, bit i for source i |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable register write data |
| pri_wr | input | 1 | Write strobe for the priority register |
| pri_wdata | input | 8 | Priority register write data |
| en_reg | output | 8 | Enable register readback |
| pri_reg | output | 8 | Priority register readback |
| vec_valid | output | 1 | A vector is being offered |
| vec_addr | output | 16 | Vector address of the chosen source |
| vec_level | output | 1 | Level of the offered vector, 1 means high |
| vec_ack | input | 1 | Core accepts the offered vector |
| reti | input | 1 | Core has finished the current service routine |
| in_svc | output | 2 | In-service bits, bit 1 high level and bit 0 low level |

## Verification
A register write takes effect at the edge that follows it. The vector that results from new register or request values is therefore due one edge after that. The bench drives inputs on falling edges and, after a register update, reads the vector two rising edges later. When only requests change, it reads one rising edge later. Acknowledge and return take effect at the next rising edge: the in-service bits and the dropped or restored valid strobe are checked on the falling edge that follows. The sweeps cover every request pattern against every priority setting, and every request pattern against every enable setting.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int unsigned SRC_CNT   = 6;
    localparam int unsigned CSR_W     = 8;
    localparam int unsigned ADDR_W    = 16;
    localparam int unsigned VEC_FIRST = 3;
    localparam int unsigned VEC_STEP  = 8;

    localparam int unsigned LVL_LO = 0;
    localparam int unsigned LVL_HI = 1;

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned N   = 6,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Fixed polling order: the lowest index has the highest standing.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs #(
    parameter int unsigned N     = 6,
    parameter int unsigned REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic [REG_W-1:0] en_wdata,
    input  logic             pri_wr,
    input  logic [REG_W-1:0] pri_wdata,
    output logic             glob_en,
    output logic [N-1:0]     src_en,
    output logic [N-1:0]     src_hi
);
    localparam int unsigned GLB_BIT = REG_W - 1;

    typedef struct packed {
        logic         glob;
        logic [N-1:0] en;
        logic [N-1:0] hi;
    } csr_t;

    csr_t csr_d, csr_q;

    always_comb begin
        csr_d = csr_q;
        if (en_wr) begin
            csr_d.glob = en_wdata[GLB_BIT];
            csr_d.en   = en_wdata[N-1:0];
        end
        if (pri_wr) begin
            csr_d.hi = pri_wdata[N-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) csr_q <= '0;
        else        csr_q <= csr_d;
    end

    assign glob_en = csr_q.glob;
    assign src_en  = csr_q.en;
    assign src_hi  = csr_q.hi;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int unsigned NUM_SRC    = SRC_CNT,
    parameter int unsigned REG_W      = CSR_W,
    parameter int unsigned VEC_W      = ADDR_W,
    parameter int unsigned VEC_BASE   = VEC_FIRST,
    parameter int unsigned VEC_STRIDE = VEC_STEP
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               en_wr,
    input  logic [REG_W-1:0]   en_wdata,
    input  logic               pri_wr,
    input  logic [REG_W-1:0]   pri_wdata,
    output logic [REG_W-1:0]   en_reg,
    output logic [REG_W-1:0]   pri_reg,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_addr,
    output logic               vec_level,
    input  logic               vec_ack,
    input  logic               reti,
    output logic [1:0]         in_svc
);
    localparam int unsigned IW      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int unsigned NLVL    = 2;
    localparam int unsigned GLB_BIT = REG_W - 1;

    typedef struct packed {
        logic [NLVL-1:0] svc;
        logic            vld;
        logic            lvl;
        logic [IW-1:0]   idx;
    } st_t;

    st_t st_d, st_q;

    logic               glob_en;
    logic [NUM_SRC-1:0] src_en;
    logic [NUM_SRC-1:0] src_hi;
    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] lvl_req [NLVL];
    logic [NLVL-1:0]    lvl_hit;
    logic [IW-1:0]      lvl_idx [NLVL];

    irq_prio_regs #(.N(NUM_SRC), .REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_wr     (en_wr),
        .en_wdata  (en_wdata),
        .pri_wr    (pri_wr),
        .pri_wdata (pri_wdata),
        .glob_en   (glob_en),
        .src_en    (src_en),
        .src_hi    (src_hi)
    );

    assign elig = irq_req & src_en & {NUM_SRC{glob_en}};

    // One fixed-order picker per priority level.
    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        if (g == LVL_HI) begin : g_hi
            assign lvl_req[g] = elig & src_hi;
        end else begin : g_lo
            assign lvl_req[g] = elig & ~src_hi;
        end
        irq_prio_pick #(.N(NUM_SRC)) u_pick (
            .req (lvl_req[g]),
            .hit (lvl_hit[g]),
            .idx (lvl_idx[g])
        );
    end

    always_comb begin
        logic [NLVL-1:0] svc_n;
        st_d  = st_q;
        svc_n = st_q.svc;
        // A return retires the innermost routine.
        if (reti) begin
            if (svc_n[LVL_HI]) svc_n[LVL_HI] = 1'b0;
            else               svc_n[LVL_LO] = 1'b0;
        end
        if (vec_ack && st_q.vld) begin
            svc_n[st_q.lvl] = 1'b1;
        end
        st_d.svc = svc_n;
        // The offer uses the updated nesting state, so an accepted vector is not offered again.
        if (lvl_hit[LVL_HI] && !svc_n[LVL_HI]) begin
            st_d.vld = 1'b1;
            st_d.lvl = 1'b1;
            st_d.idx = lvl_idx[LVL_HI];
        end else if (lvl_hit[LVL_LO] && (svc_n == '0)) begin
            st_d.vld = 1'b1;
            st_d.lvl = 1'b0;
            st_d.idx = lvl_idx[LVL_LO];
        end else begin
            st_d.vld = 1'b0;
            st_d.lvl = 1'b0;
            st_d.idx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        en_reg           = '0;
        en_reg[GLB_BIT]  = glob_en;
        en_reg[NUM_SRC-1:0] = src_en;
        pri_reg          = '0;
        pri_reg[NUM_SRC-1:0] = src_hi;
    end

    assign vec_valid = st_q.vld;
    assign vec_level = st_q.lvl;
    assign vec_addr  = VEC_W'(VEC_BASE) + VEC_W'(st_q.idx) * VEC_W'(VEC_STRIDE);
    assign in_svc    = st_q.svc;
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
    parameter int unsigned VEC_W = 16,
    parameter int unsigned REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vec_valid,
    input logic             vec_level,
    input logic [VEC_W-1:0] vec_addr,
    input logic             vec_ack,
    input logic             reti,
    input logic [1:0]       in_svc,
    input logic [REG_W-1:0] en_reg
);
    assert_vec_form_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_addr[2:0] == 3'b011 && vec_addr < VEC_W'(48)));

    assert_glob_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_reg[REG_W-1] |=> !vec_valid);

    assert_ack_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_ack && !reti) |=> (in_svc[$past(vec_level)] && !vec_valid));

    assert_low_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && in_svc[0]) |-> vec_level);

    assert_high_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_svc[1] |-> !vec_valid);

    assert_reti_inner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !vec_ack && in_svc == 2'b11) |=> (in_svc == 2'b01));
endmodule

bind irq_prio_ctrl irq_prio_chk #(.VEC_W(VEC_W), .REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vec_valid (vec_valid),
    .vec_level (vec_level),
    .vec_addr  (vec_addr),
    .vec_ack   (vec_ack),
    .reti      (reti),
    .in_svc    (in_svc),
    .en_reg    (en_reg)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  irq_req = '0;
    logic        en_wr = 1'b0, pri_wr = 1'b0;
    logic [7:0]  en_wdata = '0, pri_wdata = '0;
    logic [7:0]  en_reg, pri_reg;
    logic        vec_valid, vec_level;
    logic [15:0] vec_addr;
    logic        vec_ack = 1'b0, reti = 1'b0;
    logic [1:0]  in_svc;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .en_wr(en_wr), .en_wdata(en_wdata), .pri_wr(pri_wr), .pri_wdata(pri_wdata),
        .en_reg(en_reg), .pri_reg(pri_reg),
        .vec_valid(vec_valid), .vec_addr(vec_addr), .vec_level(vec_level),
        .vec_ack(vec_ack), .reti(reti), .in_svc(in_svc)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected offer with nothing in service: {valid, level, addr}.
    function automatic logic [17:0] model(input logic [7:0] en, input logic [7:0] pri,
                                          input logic [5:0] req);
        logic [5:0] e, h, l;
        e = req & en[5:0] & {6{en[7]}};
        h = e & pri[5:0];
        l = e & ~pri[5:0];
        for (int i = 0; i < 6; i++)
            if (h[i]) return {1'b1, 1'b1, 16'(8 * i + 3)};
        for (int i = 0; i < 6; i++)
            if (l[i]) return {1'b1, 1'b0, 16'(8 * i + 3)};
        return '0;
    endfunction

    task automatic setup(input logic [7:0] en, input logic [7:0] pri, input logic [5:0] req);
        @(negedge clk);
        en_wr = 1'b1; en_wdata = en; pri_wr = 1'b1; pri_wdata = pri; irq_req = req;
        @(negedge clk);
        en_wr = 1'b0; pri_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic cmp_offer(input string tag, input logic [17:0] exp);
        check({tag, " valid"}, int'(vec_valid), int'(exp[17]));
        if (exp[17]) begin
            check({tag, " addr"}, int'(vec_addr), int'(exp[15:0]));
            check({tag, " level"}, int'(vec_level), int'(exp[16]));
        end
    endtask

    task automatic pulse_ack;
        @(negedge clk); vec_ack = 1'b1;
        @(negedge clk); vec_ack = 1'b0;
    endtask

    task automatic pulse_reti;
        @(negedge clk); reti = 1'b1;
        @(negedge clk); reti = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state right after reset
        check("R1 en_reg", int'(en_reg), 0);
        check("R1 pri_reg", int'(pri_reg), 0);
        check("R1 in_svc", int'(in_svc), 0);
        check("R1 vec_valid", int'(vec_valid), 0);
        rst_n = 1'b1;

        // R3 R5 R6: every request pattern against every priority map, all enabled
        for (int p = 0; p < 64; p++) begin
            for (int r = 0; r < 64; r++) begin
                setup(8'hBF, 8'(p), 6'(r));
                cmp_offer("R3 R5 R6 sweep", model(8'hBF, 8'(p), 6'(r)));
            end
        end

        // R2 R4: every enable value (bit 6 ignored) against every request pattern
        for (int e = 0; e < 256; e++) begin
            for (int r = 0; r < 64; r++) begin
                setup(8'(e), 8'hD5, 6'(r));
                if (r == 0) begin
                    check("R2 en readback", int'(en_reg), e & 8'hBF);
                    check("R2 pri readback", int'(pri_reg), 8'h15);
                end
                cmp_offer("R4 gating", model(8'(e), 8'h15, 6'(r)));
            end
        end

        // R11: only requests change, vector due one edge later
        setup(8'hBF, 8'h00, 6'b000000);
        @(negedge clk); irq_req = 6'b010000;
        @(negedge clk);
        cmp_offer("R11 one-cycle", {2'b10, 16'h0023});

        // Nesting: timer 1 high, others low
        setup(8'hBF, 8'h08, 6'b001001);
        cmp_offer("R5 high wins", {2'b11, 16'h001B});
        pulse_ack;
        check("R7 svc high", int'(in_svc), 2);
        check("R7 valid drops", int'(vec_valid), 0);
        irq_req = 6'b111111;
        @(negedge clk);
        check("R9 high blocks all", int'(vec_valid), 0);
        pulse_reti;
        check("R10 clear high", int'(in_svc), 0);
        cmp_offer("R10 reoffer", {2'b11, 16'h001B});

        irq_req = 6'b000101;
        @(negedge clk);
        cmp_offer("R6 low order", {2'b10, 16'h0003});
        pulse_ack;
        check("R7 svc low", int'(in_svc), 1);
        check("R8 low blocked", int'(vec_valid), 0);
        irq_req = 6'b001101;
        @(negedge clk);
        cmp_offer("R8 high preempts", {2'b11, 16'h001B});
        pulse_ack;
        check("R7 nested svc", int'(in_svc), 3);
        check("R9 nested none", int'(vec_valid), 0);
        pulse_reti;
        check("R10 inner first", int'(in_svc), 1);
        cmp_offer("R8 high after reti", {2'b11, 16'h001B});
        irq_req = 6'b000000;
        pulse_reti;
        check("R10 clear low", int'(in_svc), 0);
        check("R10 idle", int'(vec_valid), 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule